// File: doc/BRIEF.md
# Burst-Wrapping DMA Address Generator

This block produces the source and destination addresses for one DMA channel. A load strobe captures a start address for each side. Every advance strobe then moves each side by its own step of 0, 1, 2 or 4 address units. The data mover, the bus protocol and the trigger logic sit outside the block. They only issue load and advance, and they use the two address outputs.

Each side can be set to wrap on its own. A wrapping side returns to its captured start address after every 2^N advances, so every burst sweeps the same window. This suits repeated passes over a peripheral's register bank. A side that does not wrap keeps counting up across burst boundaries. N comes from a 4-bit exponent field of the channel configuration word. That field also sizes trigger bursts elsewhere, so the wrap span follows it whether or not burst triggering is in use. The total transfer count is expected to be a whole multiple of the burst size.

Top module: `dwag_top`

## Requirements
- R1: While reset is high, and in the cycle after it is released, both address outputs read 0.
- R2: A load strobe makes both outputs equal the start inputs one clock later and restarts both burst counts at zero. Load takes priority over an advance in the same cycle.
- R3: When neither load nor advance is high, both outputs hold their values.
- R4: The 2-bit step code of each side selects the step size: 0 gives 0, 1 gives 1, 2 gives 2 and 3 gives 4 units. The address moves in the cycle after the advance.
- R5: A side with wrapping off advances linearly, start + k*step after k advances since load, across burst boundaries. The result is taken modulo 2^AW.
- R6: A side with wrapping on reads start + (k mod 2^N)*step, so after every 2^N advances it is back at its start address.
- R7: Configuration bit 14 enables wrapping for the source side and bit 15 for the destination side. Each bit affects only its own side.
- R8: The burst exponent N is configuration bits 11:8. Codes 0 to 10 give spans of 1 to 1024 transfers. Codes 11 to 15 are treated as 10.
- R9: With N = 0 and wrapping on, the side stays at its start address through any number of advances.
- R10: Step code 0 leaves the address fixed on advance, whether or not the side wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_word | input | 32 | Channel configuration: bit 14 source wrap, bit 15 destination wrap, bits 11:8 burst exponent |
| src_start | input | AW | Source start address, captured on load |
| dst_start | input | AW | Destination start address, captured on load |
| src_step | input | 2 | Source step code (0/1/2/4 units) |
| dst_step | input | 2 | Destination step code (0/1/2/4 units) |
| load | input | 1 | Capture start addresses and clear burst counts |
| advance | input | 1 | One transfer completed; step the addresses |
| src_addr | output | AW | Current source address |
| dst_addr | output | AW | Current destination address |

## Verification
All results are due exactly one clock after the strobe that causes them, because each output is a single register stage. The bench drives strobes on the falling edge and reads the outputs on the next falling edge, after the rising edge that updates them. It compares them against an arithmetic model keyed on the number of advances since the last load. The sweep covers exponents 0 to 3, all step codes and all four wrap combinations. Further runs cover the clamped exponent codes past 1024 advances, address rollover, idle gaps and load that collides with advance.

// File: rtl/dwag_pkg.sv
package dwag_pkg;

    // Largest legal burst exponent; spans run from 2^0 to 2^EXP_MAX transfers.
    localparam int EXP_MAX   = 10;
    localparam int EXP_W     = 4;
    localparam int CNT_W     = EXP_MAX;
    localparam int CFG_W     = 32;
    // Field positions are fixed because other channel logic decodes the same word.
    localparam int EXP_LSB   = 8;
    localparam int WRAP_SRC  = 14;
    localparam int WRAP_DST  = 15;
    localparam int NUM_SIDES = 2;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_ONE  = 2'd1,
        STEP_TWO  = 2'd2,
        STEP_FOUR = 2'd3
    } step_e;

    typedef struct packed {
        logic [NUM_SIDES-1:0] wrap;   // [0] source, [1] destination
        logic [EXP_W-1:0]     exp;    // already clamped to EXP_MAX
    } chan_cfg_t;

    function automatic logic [2:0] step_units(step_e s);
        case (s)
            STEP_ONE:  return 3'd1;
            STEP_TWO:  return 3'd2;
            STEP_FOUR: return 3'd4;
            default:   return 3'd0;
        endcase
    endfunction

    // Terminal count of the burst counter: 2^e - 1, in CNT_W bits.
    function automatic logic [CNT_W-1:0] span_mask(logic [EXP_W-1:0] e);
        logic [CNT_W-1:0] m;
        for (int i = 0; i < CNT_W; i++) begin
            m[i] = (i < int'(e));
        end
        return m;
    endfunction

endpackage

// File: rtl/dwag_cfg_decode.sv
module dwag_cfg_decode
    import dwag_pkg::*;
(
    input  logic [CFG_W-1:0] cfg_word,
    output chan_cfg_t        cfg
);
    logic [EXP_W-1:0] raw_exp;

    always_comb begin
        raw_exp  = cfg_word[EXP_LSB +: EXP_W];
        cfg.wrap = {cfg_word[WRAP_DST], cfg_word[WRAP_SRC]};
        cfg.exp  = (int'(raw_exp) > EXP_MAX) ? EXP_W'(EXP_MAX) : raw_exp;
    end
endmodule

// File: rtl/dwag_lane.sv
module dwag_lane
    import dwag_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             advance,
    input  logic [AW-1:0]    start,
    input  step_e            step,
    input  logic             wrap_en,
    input  logic [CNT_W-1:0] last_cnt,
    output logic [AW-1:0]    addr
);
    logic [AW-1:0]    base_q;
    logic [AW-1:0]    addr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             at_boundary;
    logic [AW-1:0]    linear_next;

    always_comb begin
        at_boundary = (cnt_q == last_cnt);
        linear_next = addr_q + AW'(step_units(step));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            addr_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            base_q <= start;
            addr_q <= start;
            cnt_q  <= '0;
        end else if (advance) begin
            if (at_boundary) begin
                cnt_q  <= '0;
                addr_q <= wrap_en ? base_q : linear_next;
            end else begin
                cnt_q  <= cnt_q + 1'b1;
                addr_q <= linear_next;
            end
        end
    end

    assign addr = addr_q;
endmodule

// File: rtl/dwag_top.sv
module dwag_top
    import dwag_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [31:0]      cfg_word,
    input  logic [AW-1:0]    src_start,
    input  logic [AW-1:0]    dst_start,
    input  logic [1:0]       src_step,
    input  logic [1:0]       dst_step,
    input  logic             load,
    input  logic             advance,
    output logic [AW-1:0]    src_addr,
    output logic [AW-1:0]    dst_addr
);
    chan_cfg_t        cfg;
    logic [CNT_W-1:0] last_cnt;
    logic [AW-1:0]    start_v [NUM_SIDES];
    step_e            step_v  [NUM_SIDES];
    logic [AW-1:0]    addr_v  [NUM_SIDES];

    dwag_cfg_decode u_dec (
        .cfg_word (cfg_word),
        .cfg      (cfg)
    );

    assign last_cnt   = span_mask(cfg.exp);
    assign start_v[0] = src_start;
    assign start_v[1] = dst_start;
    assign step_v[0]  = step_e'(src_step);
    assign step_v[1]  = step_e'(dst_step);

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        dwag_lane #(.AW(AW)) u_lane (
            .clk      (clk),
            .rst      (rst),
            .load     (load),
            .advance  (advance),
            .start    (start_v[s]),
            .step     (step_v[s]),
            .wrap_en  (cfg.wrap[s]),
            .last_cnt (last_cnt),
            .addr     (addr_v[s])
        );
    end

    assign src_addr = addr_v[0];
    assign dst_addr = addr_v[1];
endmodule

// File: rtl/dwag_chk.sv
module dwag_chk
    import dwag_pkg::*;
#(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [31:0]   cfg_word,
    input logic [AW-1:0] src_start,
    input logic [AW-1:0] dst_start,
    input logic [1:0]    src_step,
    input logic [1:0]    dst_step,
    input logic          load,
    input logic          advance,
    input logic [AW-1:0] src_addr,
    input logic [AW-1:0] dst_addr
);
    logic [AW-1:0] src_units;
    logic [AW-1:0] dst_units;
    assign src_units = AW'(step_units(step_e'(src_step)));
    assign dst_units = AW'(step_units(step_e'(dst_step)));

    // R2
    load_src_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> src_addr == $past(src_start));
    // R2
    load_dst_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> dst_addr == $past(dst_start));
    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !advance) |=> ($stable(src_addr) && $stable(dst_addr)));
    // R5
    src_linear_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && !load && !cfg_word[WRAP_SRC]) |=>
            src_addr == AW'($past(src_addr) + $past(src_units)));
    // R5
    dst_linear_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && !load && !cfg_word[WRAP_DST]) |=>
            dst_addr == AW'($past(dst_addr) + $past(dst_units)));
    // R9
    exp0_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && !load && cfg_word[WRAP_SRC] && cfg_word[11:8] == 4'd0) |=>
            $stable(src_addr));
    // R10
    zero_step_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && !load && src_step == 2'd0 && dst_step == 2'd0) |=>
            ($stable(src_addr) && $stable(dst_addr)));
endmodule

bind dwag_top dwag_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_word  (cfg_word),
    .src_start (src_start),
    .dst_start (dst_start),
    .src_step  (src_step),
    .dst_step  (dst_step),
    .load      (load),
    .advance   (advance),
    .src_addr  (src_addr),
    .dst_addr  (dst_addr)
);

// File: tb/tb_dwag_top.sv
module tb_dwag_top;
    localparam int AW     = 16;
    localparam int CLK_NS = 10;

    logic          clk = 1'b0;
    logic          rst;
    logic [31:0]   cfg_word;
    logic [AW-1:0] src_start, dst_start;
    logic [1:0]    src_step, dst_step;
    logic          load, advance;
    logic [AW-1:0] src_addr, dst_addr;

    int checks = 0;
    int errors = 0;
    int k      = 0;   // advances since the last load
    int exp_n  = 0;   // effective exponent
    logic wsrc = 1'b0, wdst = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    dwag_top #(.AW(AW)) dut (
        .clk(clk), .rst(rst), .cfg_word(cfg_word),
        .src_start(src_start), .dst_start(dst_start),
        .src_step(src_step), .dst_step(dst_step),
        .load(load), .advance(advance),
        .src_addr(src_addr), .dst_addr(dst_addr)
    );

    function automatic int units(logic [1:0] c);
        return (c == 2'd3) ? 4 : int'(c);
    endfunction

    function automatic logic [AW-1:0] model(logic [AW-1:0] st, logic [1:0] c,
                                            logic wr, int n, int kk);
        int eff = wr ? (kk % (1 << n)) : kk;
        return AW'(int'(st) + eff * units(c));
    endfunction

    task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (k=%0d n=%0d)", req, act, expv, k, exp_n);
        end
    endtask

    task automatic check_both(string req);
        check(req, src_addr, model(src_start, src_step, wsrc, exp_n, k));
        check(req, dst_addr, model(dst_start, dst_step, wdst, exp_n, k));
    endtask

    task automatic setup(int code, logic ws, logic wd, logic [1:0] ss, logic [1:0] ds,
                         logic [AW-1:0] sa, logic [AW-1:0] da);
        cfg_word = '0;
        cfg_word[11:8] = 4'(code);
        cfg_word[14] = ws;
        cfg_word[15] = wd;
        wsrc = ws; wdst = wd;
        exp_n = (code > 10) ? 10 : code;
        src_step = ss; dst_step = ds;
        src_start = sa; dst_start = da;
    endtask

    // load pulse; outputs due one clock later
    task automatic do_load(logic with_adv);
        load = 1'b1; advance = with_adv;
        @(posedge clk); @(negedge clk);
        load = 1'b0; advance = 1'b0;
        k = 0;
        check_both("R2");
    endtask

    // n back-to-back advances, each result checked one clock later
    task automatic run(int n, string req);
        advance = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
            k++;
            check_both(req);
        end
        advance = 1'b0;
    endtask

    initial begin
        rst = 1'b1; load = 1'b0; advance = 1'b0;
        setup(0, 1'b0, 1'b0, 2'd1, 2'd1, 16'h1234, 16'h5678);
        repeat (3) @(negedge clk);
        check("R1", src_addr, '0);
        check("R1", dst_addr, '0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", src_addr, '0);
        check("R1", dst_addr, '0);

        // Sweep: exponent, step codes, wrap combinations (R4 R5 R6 R7 R9 R10)
        for (int e = 0; e < 4; e++) begin
            for (int c = 0; c < 4; c++) begin
                for (int w = 0; w < 4; w++) begin
                    setup(e, w[0], w[1], 2'(c), 2'(3 - c),
                          AW'(16'h0100 + e * 16 + c), AW'(16'h8000 + w * 64));
                    do_load(1'b0);
                    run(2 * (1 << e) + 3, (w == 0) ? "R5" : "R6");
                end
            end
        end

        // Exponent 0 wrapping: source stays at start (R9); destination linear (R7)
        setup(0, 1'b1, 1'b0, 2'd3, 2'd3, 16'h0040, 16'h0040);
        do_load(1'b0);
        run(5, "R9");

        // Idle gaps: outputs hold (R3)
        setup(2, 1'b1, 1'b0, 2'd2, 2'd1, 16'h2000, 16'h3000);
        do_load(1'b0);
        for (int i = 0; i < 6; i++) begin
            run(1, "R6");
            @(negedge clk);
            check_both("R3");
        end

        // Load wins over advance; mid-burst load restarts the count (R2)
        run(1, "R6");
        setup(2, 1'b1, 1'b1, 2'd1, 2'd2, 16'h4000, 16'h5000);
        do_load(1'b1);
        run(9, "R2");

        // Linear rollover past the top of the address space (R5)
        setup(1, 1'b0, 1'b0, 2'd3, 2'd1, 16'hFFF8, 16'hFFFE);
        do_load(1'b0);
        run(5, "R5");

        // Full span 1024 and clamped codes 11 and 15 (R8)
        setup(10, 1'b1, 1'b0, 2'd1, 2'd1, 16'h0010, 16'h0020);
        do_load(1'b0);
        run(1026, "R8");
        setup(11, 1'b1, 1'b1, 2'd2, 2'd1, 16'h0100, 16'h0200);
        do_load(1'b0);
        run(1026, "R8");
        setup(15, 1'b0, 1'b1, 2'd1, 2'd3, 16'h0300, 16'h0400);
        do_load(1'b0);
        run(1026, "R8");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule